// File: doc/BRIEF.md
# Physical Tag Pool with Silent-Write Register File

This block hands out physical register tags to the rename stage and takes them back when instructions retire. The unallocated tags live on a stack, so the tag freed most recently is the next one handed out. A retire push and a rename pop may land in the same cycle. When they do, the retiring tag goes straight to the rename side and the stack is left alone. After a mispredict, the recovery logic returns the wrong-path tags in beats of up to four. A busy flag stays high until the final beat has been accepted.

Next to the stack sits a small physical register file. A freed register is never cleared, so it keeps its last value. Every write is compared against the value already stored at the target. If the two are equal, the array write is skipped and a suppressed-write counter goes up by one. Reusing tags in stack order makes it likely that a reallocated register still holds a value equal to its new result.

Top module: `phys_tag_pool`

## Requirements
- R1: In the cycle after reset, `alloc_vld_o`, `empty_o` and `busy_o` are low and `supp_cnt_o` is 0. The stack holds tags 16 to 63, and successive pops return 16, 17, 18 and so on, in that order.
- R2: A pop is accepted only when `alloc_req_i` is high, the block is not busy and `rcv_vld_i` is low. In the next cycle `alloc_vld_o` is high and `alloc_tag_o` is the tag most recently pushed that has not yet been popped.
- R3: If a pop is accepted while `free_vld_i` is high, the next `alloc_tag_o` equals that cycle's `free_tag_i`. The stack contents and depth do not change, and this also holds when the stack is empty.
- R4: `empty_o` is high exactly when the stack holds no tag. A pop request while empty with no retire push gives no grant and leaves the stack unchanged.
- R5: In a recovery beat, each lane k (tag in `rcv_tags_i[6k+5:6k]`) whose `rcv_mask_i[k]` is set is pushed, lane 0 first. A retire push in the same cycle is placed last, on top.
- R6: A recovery beat with `rcv_last_i` low sets `busy_o` from the next cycle. A beat with `rcv_last_i` high clears it. A pop request during busy or during any recovery beat gets no grant.
- R7: `rd_data_o` shows, one cycle after `rd_tag_i` is sampled, the last value written to that register. Freeing and reallocating a tag does not change that value.
- R8: A write whose data equals the stored value leaves the array unchanged and increments the 32-bit `supp_cnt_o` by one in the next cycle. A write with different data updates the array and leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req_i | input | 1 | Rename requests one tag |
| alloc_vld_o | output | 1 | Granted tag valid (registered) |
| alloc_tag_o | output | 6 | Granted tag |
| empty_o | output | 1 | No tag stored on the stack |
| free_vld_i | input | 1 | Retire returns a tag |
| free_tag_i | input | 6 | Returned tag |
| rcv_vld_i | input | 1 | Recovery beat valid |
| rcv_mask_i | input | 4 | Lane enables of the beat |
| rcv_tags_i | input | 24 | Four lane tags, lane k in bits 6k+5:6k |
| rcv_last_i | input | 1 | Final beat of the batch |
| busy_o | output | 1 | Recovery batch in progress |
| wr_en_i | input | 1 | Register write enable |
| wr_tag_i | input | 6 | Register written |
| wr_data_i | input | 32 | Write data |
| rd_tag_i | input | 6 | Register read |
| rd_data_o | output | 32 | Read data, one cycle later |
| supp_cnt_o | output | 32 | Number of suppressed writes |

## Verification
The properties check the following on every cycle:
- a same-cycle push and pop forwards the pushed tag;
- an empty pop or any pop during recovery yields no grant;
- the final beat clears busy;
- the stack depth never exceeds its capacity;
- the counter moves by at most one and only when a write occurs.

Only the bench scenarios can show the rest, because it needs the history of the stack and the register file. That covers the exact pop order after mixed pushes and recovery lane ordering, the preload order, and the retention of a value across a free and reallocate cycle. It also covers whether a given write was counted as a match.

// File: rtl/tagpool_pkg.sv
package tagpool_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_POP    = 2'd1,
    OP_BYPASS = 2'd2,
    OP_PUSH   = 2'd3
  } lifo_op_e;
endpackage

// File: rtl/tag_lifo.sv
module tag_lifo
  import tagpool_pkg::*;
#(
  parameter int NUM_PREGS = 64,
  parameter int NUM_AREGS = 16,
  parameter int RCV_LANES = 4,
  localparam int TAG_W = $clog2(NUM_PREGS),
  localparam int DEPTH = NUM_PREGS - NUM_AREGS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       alloc_req_i,
  output logic                       alloc_vld_o,
  output logic [TAG_W-1:0]           alloc_tag_o,
  output logic                       empty_o,
  input  logic                       free_vld_i,
  input  logic [TAG_W-1:0]           free_tag_i,
  input  logic                       rcv_vld_i,
  input  logic [RCV_LANES-1:0]       rcv_mask_i,
  input  logic [RCV_LANES*TAG_W-1:0] rcv_tags_i,
  input  logic                       rcv_last_i,
  output logic                       busy_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] stk [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             vld_q;
  logic [TAG_W-1:0] tag_q;

  lifo_op_e         op;
  logic             pop_ok;
  logic [CNT_W:0]   run;
  logic [CNT_W-1:0] lane_pos [RCV_LANES];
  logic [RCV_LANES-1:0] lane_we;
  logic [CNT_W-1:0] ret_pos;

  always_comb begin
    pop_ok = alloc_req_i && !busy_q && !rcv_vld_i && ((cnt_q != '0) || free_vld_i);
    op = OP_IDLE;
    if (pop_ok)                      op = free_vld_i ? OP_BYPASS : OP_POP;
    else if (rcv_vld_i || free_vld_i) op = OP_PUSH;
    run = {1'b0, cnt_q};
    for (int k = 0; k < RCV_LANES; k++) begin
      lane_we[k]  = rcv_vld_i && rcv_mask_i[k];
      lane_pos[k] = run[CNT_W-1:0];
      if (lane_we[k]) run = run + (CNT_W+1)'(1);
    end
    ret_pos = run[CNT_W-1:0];
    if (free_vld_i) run = run + (CNT_W+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CNT_W'(DEPTH);
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      tag_q  <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= TAG_W'(NUM_PREGS - 1 - i);
    end else begin
      vld_q <= 1'b0;
      unique case (op)
        OP_BYPASS: begin
          vld_q <= 1'b1;
          tag_q <= free_tag_i;
        end
        OP_POP: begin
          vld_q <= 1'b1;
          tag_q <= stk[cnt_q - CNT_W'(1)];
          cnt_q <= cnt_q - CNT_W'(1);
        end
        OP_PUSH: begin
          for (int k = 0; k < RCV_LANES; k++)
            if (lane_we[k]) stk[lane_pos[k]] <= rcv_tags_i[k*TAG_W +: TAG_W];
          if (free_vld_i) stk[ret_pos] <= free_tag_i;
          cnt_q <= run[CNT_W-1:0];
        end
        default: ;
      endcase
      if (rcv_vld_i) busy_q <= !rcv_last_i;
    end
  end

  assign alloc_vld_o = vld_q;
  assign alloc_tag_o = tag_q;
  assign empty_o     = (cnt_q == '0);
  assign busy_o      = busy_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) op == OP_PUSH |-> run <= (CNT_W+1)'(DEPTH)); // R4
  AST_BYPASS_TAG: assert property (@(posedge clk) disable iff (rst) alloc_req_i && !busy_q && !rcv_vld_i && free_vld_i |=> vld_q && tag_q == $past(free_tag_i)); // R3
  AST_EMPTY_NO_GRANT: assert property (@(posedge clk) disable iff (rst) empty_o && alloc_req_i && !free_vld_i && !rcv_vld_i |=> !vld_q && empty_o); // R4
  AST_BUSY_NO_GRANT: assert property (@(posedge clk) disable iff (rst) busy_q || rcv_vld_i |=> !vld_q); // R6
  AST_LAST_CLEARS: assert property (@(posedge clk) disable iff (rst) rcv_vld_i && rcv_last_i |=> !busy_q); // R6
endmodule

// File: rtl/silent_prf.sv
module silent_prf #(
  parameter int NUM_PREGS = 64,
  parameter int DATA_W    = 32,
  parameter int SCNT_W    = 32,
  localparam int TAG_W = $clog2(NUM_PREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [SCNT_W-1:0] supp_cnt_o
);
  logic [DATA_W-1:0] mem [NUM_PREGS];
  logic [DATA_W-1:0] stale;
  logic              same;
  logic [DATA_W-1:0] rd_q;
  logic [SCNT_W-1:0] supp_q;

  assign stale = mem[wr_tag_i];
  assign same  = wr_en_i && (stale == wr_data_i);

  always_ff @(posedge clk) begin
    if (wr_en_i && !same) mem[wr_tag_i] <= wr_data_i;
    rd_q <= mem[rd_tag_i];
  end

  always_ff @(posedge clk) begin
    if (rst)       supp_q <= '0;
    else if (same) supp_q <= supp_q + SCNT_W'(1);
  end

  assign rd_data_o  = rd_q;
  assign supp_cnt_o = supp_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst) !wr_en_i |=> $stable(supp_cnt_o)); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (supp_cnt_o - $past(supp_cnt_o)) <= SCNT_W'(1)); // R8
endmodule

// File: rtl/phys_tag_pool.sv
module phys_tag_pool #(
  parameter int NUM_PREGS = 64,
  parameter int NUM_AREGS = 16,
  parameter int RCV_LANES = 4,
  parameter int DATA_W    = 32,
  parameter int SCNT_W    = 32,
  localparam int TAG_W = $clog2(NUM_PREGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       alloc_req_i,
  output logic                       alloc_vld_o,
  output logic [TAG_W-1:0]           alloc_tag_o,
  output logic                       empty_o,
  input  logic                       free_vld_i,
  input  logic [TAG_W-1:0]           free_tag_i,
  input  logic                       rcv_vld_i,
  input  logic [RCV_LANES-1:0]       rcv_mask_i,
  input  logic [RCV_LANES*TAG_W-1:0] rcv_tags_i,
  input  logic                       rcv_last_i,
  output logic                       busy_o,
  input  logic                       wr_en_i,
  input  logic [TAG_W-1:0]           wr_tag_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [TAG_W-1:0]           rd_tag_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic [SCNT_W-1:0]          supp_cnt_o
);
  tag_lifo #(
    .NUM_PREGS(NUM_PREGS), .NUM_AREGS(NUM_AREGS), .RCV_LANES(RCV_LANES)
  ) u_lifo (
    .clk(clk), .rst(rst),
    .alloc_req_i(alloc_req_i), .alloc_vld_o(alloc_vld_o), .alloc_tag_o(alloc_tag_o),
    .empty_o(empty_o),
    .free_vld_i(free_vld_i), .free_tag_i(free_tag_i),
    .rcv_vld_i(rcv_vld_i), .rcv_mask_i(rcv_mask_i), .rcv_tags_i(rcv_tags_i),
    .rcv_last_i(rcv_last_i), .busy_o(busy_o)
  );

  silent_prf #(
    .NUM_PREGS(NUM_PREGS), .DATA_W(DATA_W), .SCNT_W(SCNT_W)
  ) u_prf (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en_i), .wr_tag_i(wr_tag_i), .wr_data_i(wr_data_i),
    .rd_tag_i(rd_tag_i), .rd_data_o(rd_data_o), .supp_cnt_o(supp_cnt_o)
  );
endmodule

// File: tb/tb_phys_tag_pool.sv
`timescale 1ns/1ps
module tb_phys_tag_pool;
  logic        clk = 1'b0;
  logic        rst;
  logic        s_req, s_fv, s_rv, s_last, s_we;
  logic [5:0]  s_ftag, s_wtag, s_rdtag;
  logic [3:0]  s_mask;
  logic [23:0] s_rtags;
  logic [31:0] s_wdata;
  logic        alloc_vld_o, empty_o, busy_o;
  logic [5:0]  alloc_tag_o;
  logic [31:0] rd_data_o, supp_cnt_o;

  always #2.5 clk = ~clk;

  phys_tag_pool dut (
    .clk(clk), .rst(rst),
    .alloc_req_i(s_req), .alloc_vld_o(alloc_vld_o), .alloc_tag_o(alloc_tag_o),
    .empty_o(empty_o), .free_vld_i(s_fv), .free_tag_i(s_ftag),
    .rcv_vld_i(s_rv), .rcv_mask_i(s_mask), .rcv_tags_i(s_rtags), .rcv_last_i(s_last),
    .busy_o(busy_o), .wr_en_i(s_we), .wr_tag_i(s_wtag), .wr_data_i(s_wdata),
    .rd_tag_i(s_rdtag), .rd_data_o(rd_data_o), .supp_cnt_o(supp_cnt_o)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int mstk [64];
  int mcnt;
  bit mbusy;
  logic [31:0] mprf [64];
  bit mval [64];
  int unsigned msupp;
  bit chk_supp;
  int pool [64];
  int pn = 0;

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic clr();
    s_req = 0; s_fv = 0; s_ftag = 0; s_rv = 0; s_mask = 0; s_rtags = 0;
    s_last = 0; s_we = 0; s_wtag = 0; s_wdata = 0; s_rdtag = 0;
  endtask

  task automatic drop(int t);
    for (int i = 0; i < pn; i++)
      if (pool[i] == t) begin pool[i] = pool[pn-1]; pn--; return; end
  endtask

  task automatic take(output int t);
    int idx;
    idx = $urandom % pn;
    t = pool[idx];
    pool[idx] = pool[pn-1];
    pn--;
  endtask

  function automatic bit pop_allowed();
    return s_req && !mbusy && !s_rv && (mcnt != 0 || s_fv);
  endfunction

  task automatic tick(string lbl);
    bit evld = 0;
    int etag = 0;
    string al = "R2";
    logic [31:0] erd;
    bit erd_ok;
    erd_ok = mval[s_rdtag];
    erd = mprf[s_rdtag];
    if (s_req && !pop_allowed()) al = (s_rv || mbusy) ? "R6" : "R4";
    if (pop_allowed()) begin
      evld = 1;
      if (s_fv) begin etag = s_ftag; al = "R3"; end
      else begin mcnt--; etag = mstk[mcnt]; end
    end else begin
      if (s_rv) begin
        al = "R5";
        for (int k = 0; k < 4; k++)
          if (s_mask[k]) begin mstk[mcnt] = s_rtags[k*6 +: 6]; mcnt++; end
      end
      if (s_fv) begin mstk[mcnt] = s_ftag; mcnt++; end
    end
    if (s_rv) mbusy = !s_last;
    if (s_we) begin
      if (mval[s_wtag] && mprf[s_wtag] == s_wdata) msupp++;
      else begin mprf[s_wtag] = s_wdata; mval[s_wtag] = 1; end
    end
    if (lbl != "") al = lbl;
    @(posedge clk); #1;
    chk(alloc_vld_o == evld, al, "alloc_vld", alloc_vld_o, evld);
    if (evld) begin
      chk(alloc_tag_o == etag, al, "alloc_tag", alloc_tag_o, etag);
      pool[pn] = etag; pn++;
    end
    chk(empty_o == (mcnt == 0), "R4", "empty", empty_o, mcnt == 0);
    chk(busy_o == mbusy, "R6", "busy", busy_o, mbusy);
    if (erd_ok) chk(rd_data_o == erd, "R7", "rd_data", rd_data_o, erd);
    if (chk_supp) chk(supp_cnt_o == msupp, "R8", "supp_cnt", supp_cnt_o, msupp);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int a, b, c, d, t;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) begin mval[i] = 0; mprf[i] = 0; end
    for (int i = 0; i < 48; i++) mstk[i] = 63 - i;
    mcnt = 48; mbusy = 0; msupp = 0; chk_supp = 0;
    rst = 1; clr();
    repeat (3) @(posedge clk);
    #1;
    chk(alloc_vld_o == 0, "R1", "reset alloc_vld", alloc_vld_o, 0);
    chk(empty_o == 0, "R1", "reset empty", empty_o, 0);
    chk(busy_o == 0, "R1", "reset busy", busy_o, 0);
    chk(supp_cnt_o == 0, "R1", "reset supp_cnt", supp_cnt_o, 0);
    rst = 0;
    // fill register file with known values (counter not yet modelled)
    for (int i = 0; i < 64; i++) begin
      clr(); s_we = 1; s_wtag = 6'(i); s_wdata = 32'h5A00_0000 + i; tick("R7");
    end
    clr(); tick("");
    msupp = supp_cnt_o; chk_supp = 1;
    // R1: preload order 16,17,18
    repeat (3) begin clr(); s_req = 1; tick("R1"); end
    // R2: push then pop returns latest
    drop(18); clr(); s_fv = 1; s_ftag = 18; tick("R2");
    clr(); s_req = 1; tick("R2");
    // R3: same-cycle bypass, stack untouched
    drop(17); clr(); s_req = 1; s_fv = 1; s_ftag = 17; tick("R3");
    clr(); s_req = 1; tick("R3");
    // R4: drain and pop while empty
    while (mcnt > 0) begin clr(); s_req = 1; tick("R4"); end
    clr(); s_req = 1; tick("R4");
    clr(); s_req = 1; tick("R4");
    // R3: bypass while empty
    take(t); clr(); s_req = 1; s_fv = 1; s_ftag = 6'(t); tick("R3");
    // R5/R6: two-beat recovery with retire push on last beat
    take(a); take(b); take(c); take(d);
    clr(); s_req = 1; s_rv = 1; s_mask = 4'b0101;
    s_rtags[0 +: 6] = 6'(a); s_rtags[12 +: 6] = 6'(b); tick("R6");
    clr(); s_req = 1; tick("R6");
    clr(); s_rv = 1; s_mask = 4'b1000; s_rtags[18 +: 6] = 6'(c); s_last = 1;
    s_fv = 1; s_ftag = 6'(d); s_req = 1; tick("R5");
    repeat (4) begin clr(); s_req = 1; tick("R5"); end
    // R7: value survives free and reallocate
    take(t);
    clr(); s_we = 1; s_wtag = 6'(t); s_wdata = 32'hCAFE_0001; tick("R7");
    clr(); s_fv = 1; s_ftag = 6'(t); tick("R7");
    clr(); s_req = 1; tick("R7");
    clr(); s_rdtag = 6'(t); tick("R7");
    clr(); tick("R7");
    // R8: matching write suppressed, differing write lands
    clr(); s_we = 1; s_wtag = 5; s_wdata = mprf[5]; tick("R8");
    clr(); s_we = 1; s_wtag = 5; s_wdata = mprf[5] ^ 32'h1; tick("R8");
    clr(); s_we = 1; s_wtag = 5; s_wdata = mprf[5]; s_rdtag = 5; tick("R8");
    clr(); s_rdtag = 5; tick("R7");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      clr();
      s_req = 1'($urandom % 2);
      if (pn > 0 && ($urandom % 3) == 0) begin take(t); s_fv = 1; s_ftag = 6'(t); end
      if (mbusy || (pn > 0 && ($urandom % 20) == 0)) begin
        s_rv = 1;
        for (int k = 0; k < 4; k++)
          if (pn > 0 && ($urandom % 2) == 1) begin
            take(t); s_mask[k] = 1; s_rtags[k*6 +: 6] = 6'(t);
          end
        s_last = (pn == 0) || (($urandom % 3) == 0);
      end
      s_we = 1'($urandom % 2);
      s_wtag = 6'($urandom % 64);
      s_wdata = ($urandom % 2) ? mprf[s_wtag] : ($urandom % 4);
      s_rdtag = 6'($urandom % 64);
      tick("");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule